// File: doc/BRIEF.md
# Fracturable Look-Up Table Slice

This block is one programmable logic element: a single 64-bit storage array addressed by six select inputs, followed by two output registers. The storage array is filled through a configuration port that accepts a word of a parameter-set width per load pulse. With a width of one the port is serial; with a wider setting it is parallel. Once loaded, the array can act as one 6-input function or as two 5-input functions that share their low five inputs. It can also be used as a 64x1 memory that is written during operation, or as a shift register with a selectable tap.

Each of the two function outputs feeds its own flip-flop. Each flip-flop has a clock enable and a synchronous reset. A per-output bypass bit chooses whether the pin shows the flip-flop or the combinational value. The slice is meant to be placed in large numbers inside a programmable fabric. The mode, bypass and enable inputs would come from configuration bits held elsewhere.

Top module: `flex_lut_slice`

## Requirements
- R1: In mode 0 (single 6-input function) the combinational high output equals table bit `sel`, where `sel[5:0]` is the full select input.
- R2: The combinational low output always equals table bit `{0, sel[4:0]}`. In mode 1 (dual 5-input) the combinational high output equals table bit `{1, sel[4:0]}` whatever the value of `sel[5]`.
- R3: Each cycle with `cfg_load` high moves the table down by CFG_W bits and places `cfg_word` in the top CFG_W bits. After 64/CFG_W loads, the first word loaded occupies bits [CFG_W-1:0]. `cfg_load` takes priority over `wr_en` in every mode.
- R4: In mode 2 (memory), a clock edge with `wr_en` high writes `wr_bit` into table bit `sel`. The read of any bit is combinational, so the new value is visible right after that edge.
- R5: In mode 3 (shift), a clock edge with `wr_en` high moves every table bit i up to position i+1 and loads `wr_bit` into bit 0. The high output reads the bit at position `sel`.
- R6: In modes 0 and 1, `wr_en` has no effect on the table contents.
- R7: With the bypass bit of an output low, the output pin shows its flip-flop. That flip-flop loads the combinational value present before a clock edge when its enable bit is high. Bit 0 of `ce` and `bypass` belongs to the high output and bit 1 to the low output.
- R8: A flip-flop whose enable bit is low keeps its value across a clock edge.
- R9: `rst` is synchronous and active high. It clears both flip-flops to 0 and overrides the enables. It leaves the table unchanged.
- R10: With the bypass bit of an output high, the output pin shows the combinational value of that output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes and output flip-flops |
| rst | input | 1 | Synchronous active-high clear of the output flip-flops |
| mode | input | 2 | 0 single function, 1 dual function, 2 memory, 3 shift |
| sel | input | 6 | Table select / memory address / shift tap |
| wr_bit | input | 1 | Write data in memory mode, serial input in shift mode |
| wr_en | input | 1 | Write enable (mode 2) or shift enable (mode 3) |
| cfg_load | input | 1 | Load one configuration word into the table |
| cfg_word | input | 8 | Configuration word (CFG_W bits) |
| ce | input | 2 | Flip-flop enables, bit 0 high output, bit 1 low output |
| bypass | input | 2 | 1 selects the combinational value for that output |
| out_hi | output | 1 | High function output (tap output in shift mode) |
| out_lo | output | 1 | Low function output |

## Verification
The bench sweeps all 64 addresses after a configuration load that happens while a memory write is also requested. A design that let the write win over the load, or that reversed the word order, would show a wrong bit at some address. In dual mode it drives the select input with bit 5 both set and cleared. A design that used bit 5 for the high output would then read the lower half. Writes and shifts are interleaved with taps at the ends of the array, which exposes an off-by-one tap or a shift in the wrong direction. Reset is applied while the enables are high, and the enables are dropped while the data changes, which catches a reset with lower priority than the enable or a register that ignores its enable.

// File: rtl/flex_lut_pkg.sv
package flex_lut_pkg;
   typedef enum logic [1:0] {
      FM_LUT6  = 2'd0,
      FM_DUAL5 = 2'd1,
      FM_RAM   = 2'd2,
      FM_SHIFT = 2'd3
   } fmode_e;
endpackage

// File: rtl/lut_store.sv
module lut_store
   import flex_lut_pkg::*;
#(
   parameter int K     = 6,
   parameter int CFG_W = 8,
   localparam int DEPTH = 1 << K
) (
   input  logic             clk,
   input  logic             rst,
   input  fmode_e           mode,
   input  logic [K-1:0]     sel,
   input  logic             wr_bit,
   input  logic             wr_en,
   input  logic             cfg_load,
   input  logic [CFG_W-1:0] cfg_word,
   output logic [DEPTH-1:0] table_q
);
   logic [DEPTH-1:0] cfg_next;

   // Configuration variant: full replace when one word fills the table,
   // otherwise shift the word in from the top.
   generate
      if (CFG_W == DEPTH) begin : g_cfg_full
         assign cfg_next = cfg_word;
      end else begin : g_cfg_shift
         assign cfg_next = {cfg_word, table_q[DEPTH-1:CFG_W]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (cfg_load) begin
         table_q <= cfg_next;
      end else if (wr_en && mode == FM_RAM) begin
         table_q[sel] <= wr_bit;
      end else if (wr_en && mode == FM_SHIFT) begin
         table_q <= {table_q[DEPTH-2:0], wr_bit};
      end
   end

   assert_cfg_top_R3: assert property (@(posedge clk) disable iff (rst)
      cfg_load |=> table_q[DEPTH-1 -: CFG_W] == $past(cfg_word));

   assert_ram_write_R4: assert property (@(posedge clk) disable iff (rst)
      (mode == FM_RAM && wr_en && !cfg_load) |=> table_q[$past(sel)] == $past(wr_bit));

   assert_shift_in_R5: assert property (@(posedge clk) disable iff (rst)
      (mode == FM_SHIFT && wr_en && !cfg_load) |=>
         (table_q[0] == $past(wr_bit)) && (table_q[DEPTH-1:1] == $past(table_q[DEPTH-2:0])));

   assert_lut_frozen_R6: assert property (@(posedge clk) disable iff (rst)
      ((mode == FM_LUT6 || mode == FM_DUAL5) && !cfg_load) |=> $stable(table_q));
endmodule

// File: rtl/lut_read.sv
module lut_read
   import flex_lut_pkg::*;
#(
   parameter int K = 6,
   localparam int DEPTH = 1 << K
) (
   input  logic [DEPTH-1:0] table_q,
   input  fmode_e           mode,
   input  logic [K-1:0]     sel,
   output logic             f_hi,
   output logic             f_lo
);
   logic [K-1:0] hi_idx;
   logic [K-1:0] lo_idx;

   always_comb begin
      lo_idx = {1'b0, sel[K-2:0]};
      hi_idx = (mode == FM_DUAL5) ? {1'b1, sel[K-2:0]} : sel;
      f_hi   = table_q[hi_idx];
      f_lo   = table_q[lo_idx];
   end
endmodule

// File: rtl/lut_out_reg.sv
module lut_out_reg (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic bypass,
   input  logic d,
   output logic y
);
   logic q;

   always_ff @(posedge clk) begin
      if (rst)     q <= 1'b0;
      else if (ce) q <= d;
   end

   assign y = bypass ? d : q;

   assert_clear_R9: assert property (@(posedge clk)
      rst |=> (q == 1'b0));

   assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
      ce |=> (q == $past(d)));

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(q));
endmodule

// File: rtl/flex_lut_slice.sv
module flex_lut_slice
   import flex_lut_pkg::*;
#(
   parameter int K     = 6,
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode,
   input  logic [K-1:0]     sel,
   input  logic             wr_bit,
   input  logic             wr_en,
   input  logic             cfg_load,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic [1:0]       ce,
   input  logic [1:0]       bypass,
   output logic             out_hi,
   output logic             out_lo
);
   localparam int DEPTH = 1 << K;

   generate
      if (K < 2) begin : g_bad_k
         $error("flex_lut_slice: K must be at least 2");
      end
      if (CFG_W < 1 || CFG_W > DEPTH || (DEPTH % CFG_W) != 0) begin : g_bad_cfg
         $error("flex_lut_slice: CFG_W must divide the table depth");
      end
   endgenerate

   fmode_e           mode_e;
   logic [DEPTH-1:0] table_q;
   logic [1:0]       f_comb;
   logic [1:0]       f_pin;

   assign mode_e = fmode_e'(mode);

   lut_store #(.K(K), .CFG_W(CFG_W)) u_store (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode_e),
      .sel      (sel),
      .wr_bit   (wr_bit),
      .wr_en    (wr_en),
      .cfg_load (cfg_load),
      .cfg_word (cfg_word),
      .table_q  (table_q)
   );

   lut_read #(.K(K)) u_read (
      .table_q (table_q),
      .mode    (mode_e),
      .sel     (sel),
      .f_hi    (f_comb[0]),
      .f_lo    (f_comb[1])
   );

   for (genvar i = 0; i < 2; i++) begin : g_out
      lut_out_reg u_reg (
         .clk    (clk),
         .rst    (rst),
         .ce     (ce[i]),
         .bypass (bypass[i]),
         .d      (f_comb[i]),
         .y      (f_pin[i])
      );
   end

   assign out_hi = f_pin[0];
   assign out_lo = f_pin[1];
endmodule

// File: tb/tb_flex_lut_slice.sv
module tb_flex_lut_slice;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode = 2'd0;
   logic [5:0] sel = '0;
   logic       wr_bit = 1'b0;
   logic       wr_en = 1'b0;
   logic       cfg_load = 1'b0;
   logic [7:0] cfg_word = '0;
   logic [1:0] ce = 2'b11;
   logic [1:0] bypass = 2'b00;
   logic       out_hi, out_lo;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural reference state
   logic [63:0] m_tab = '0;
   logic        m_r0 = 1'b0;
   logic        m_r1 = 1'b0;

   always #10 clk = ~clk;

   flex_lut_slice dut (
      .clk(clk), .rst(rst), .mode(mode), .sel(sel), .wr_bit(wr_bit),
      .wr_en(wr_en), .cfg_load(cfg_load), .cfg_word(cfg_word),
      .ce(ce), .bypass(bypass), .out_hi(out_hi), .out_lo(out_lo)
   );

   function automatic logic comb_hi();
      int idx = int'(sel);
      if (mode == 2'd1) idx = 32 + int'(sel[4:0]);
      return m_tab[idx];
   endfunction

   function automatic logic comb_lo();
      return m_tab[int'(sel[4:0])];
   endfunction

   task automatic compare(string tag);
      logic e_hi, e_lo;
      e_hi = bypass[0] ? comb_hi() : m_r0;
      e_lo = bypass[1] ? comb_lo() : m_r1;
      total++;
      if (out_hi !== e_hi) begin
         bad++;
         $display("FAIL %s out_hi actual=%b expected=%b (mode=%0d sel=%0d)", tag, out_hi, e_hi, mode, sel);
      end
      total++;
      if (out_lo !== e_lo) begin
         bad++;
         $display("FAIL %s out_lo actual=%b expected=%b (mode=%0d sel=%0d)", tag, out_lo, e_lo, mode, sel);
      end
   endtask

   // inputs are set just after a falling edge; check, then advance the model
   task automatic step(string tag);
      logic c_hi, c_lo;
      #1;
      compare(tag);
      @(posedge clk);
      c_hi = comb_hi();
      c_lo = comb_lo();
      if (rst) begin
         m_r0 = 1'b0; m_r1 = 1'b0;
      end else begin
         if (ce[0]) m_r0 = c_hi;
         if (ce[1]) m_r1 = c_lo;
      end
      if (cfg_load) m_tab = {cfg_word, m_tab[63:8]};
      else if (wr_en && mode == 2'd2) m_tab[sel] = wr_bit;
      else if (wr_en && mode == 2'd3) m_tab = {m_tab[62:0], wr_bit};
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      // R9: reset state, registered outputs read 0
      rst = 1'b1; bypass = 2'b00;
      step("R9");
      step("R9");
      rst = 1'b0;

      // R3: configuration load while a memory write is also requested
      mode = 2'd2; wr_en = 1'b1; bypass = 2'b11;
      for (int i = 0; i < 8; i++) begin
         cfg_load = 1'b1; cfg_word = 8'($urandom); sel = 6'($urandom); wr_bit = 1'($urandom);
         step("R3");
      end
      cfg_load = 1'b0; wr_en = 1'b0;

      // R1: full sweep of the single 6-input function
      mode = 2'd0;
      for (int a = 0; a < 64; a++) begin
         sel = 6'(a); step("R1");
      end

      // R2: dual 5-input sweep with the top select bit both set and clear
      mode = 2'd1;
      for (int a = 0; a < 64; a++) begin
         sel = 6'(a); step("R2");
      end

      // R6: write enable in function modes leaves the table alone
      for (int i = 0; i < 24; i++) begin
         mode = 2'(i % 2); wr_en = 1'b1; wr_bit = 1'($urandom); sel = 6'($urandom);
         step("R6");
      end
      wr_en = 1'b0; mode = 2'd0;
      for (int a = 0; a < 64; a++) begin
         sel = 6'(a); step("R6");
      end

      // R4: memory mode, writes and reads including end addresses
      mode = 2'd2;
      for (int i = 0; i < 80; i++) begin
         sel = (i % 10 == 0) ? 6'd63 : (i % 10 == 1) ? 6'd0 : 6'($urandom);
         wr_bit = 1'($urandom); wr_en = 1'($urandom);
         step("R4");
      end

      // R5: shift mode, random shift enables, taps at both ends
      mode = 2'd3;
      for (int i = 0; i < 80; i++) begin
         sel = (i % 7 == 0) ? 6'd0 : (i % 7 == 1) ? 6'd63 : 6'($urandom);
         wr_bit = 1'($urandom); wr_en = 1'($urandom);
         step("R5");
      end
      wr_en = 1'b0;

      // R7: registered outputs with both enables high
      bypass = 2'b00; ce = 2'b11;
      for (int i = 0; i < 40; i++) begin
         mode = 2'($urandom % 2); sel = 6'($urandom); step("R7");
      end

      // R8: enables toggled independently
      for (int i = 0; i < 40; i++) begin
         mode = 2'($urandom % 2); sel = 6'($urandom); ce = 2'($urandom); step("R8");
      end

      // R9: reset mid-run with enables high, table must survive
      ce = 2'b11;
      for (int i = 0; i < 30; i++) begin
         sel = 6'($urandom); rst = (i % 4 == 2); step("R9");
      end
      rst = 1'b0; bypass = 2'b11;
      for (int a = 0; a < 64; a++) begin
         sel = 6'(a); step("R9");
      end

      // R10: mixed bypass settings
      for (int i = 0; i < 30; i++) begin
         bypass = (i % 2 == 0) ? 2'b01 : 2'b10;
         mode = 2'($urandom % 2); sel = 6'($urandom); ce = 2'($urandom);
         step("R10");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule